// File: doc/BRIEF.md
# Dual-Source Ready Synchronizer

This block takes completion indications from up to two bus targets and turns them into a single ready level for the processor. Each indication counts only while its own active-low select line is low. A high indication means the addressed target has finished its read or write. The qualified indications are ORed, and the result is retimed to the processor clock. The output register is clocked on the falling edge, so the level the processor samples on its next rising edge stays put long enough.

A mode input sets the number of retiming stages. With the mode high, the qualified level is sampled once, at the falling edge, which suits targets that already run on the processor clock. With the mode low, an asserting level must first pass a rising-edge stage and then the falling-edge stage. A deasserting level skips the first stage and clears the output at the very next falling edge. This asymmetry keeps early negation fast while guarding the assertion path against metastability. The mode should be tied high when it is not driven.

Top module: `dual_ready_sync`

## Requirements
- R1: Source i (bit i of `done_i`) counts only while bit i of `sel_ni` is low. A high done bit whose select bit is high has no effect on `ready_o`.
- R2: The qualified sources are ORed, so one qualified high done bit is enough for ready to be requested.
- R3: With `single_sync_i` = 1, `ready_o` takes the qualified level present at each falling clock edge. This applies both to rising and to falling levels.
- R4: With `single_sync_i` = 0, `ready_o` rises only after the qualified level has been high at a rising edge (first stage) and is still high at the next falling edge. A pulse that is high only across a falling edge never raises `ready_o`.
- R5: With `single_sync_i` = 0, a low qualified level at a falling edge drives `ready_o` low at that edge. This holds even when the first stage holds a high level.
- R6: `ready_o` changes only at falling clock edges (or on reset). It is constant from each falling edge through the following rising edge.
- R7: `rst_ni` low clears `ready_o` and the first stage to 0 at once, without waiting for a clock edge.
- R8: When the inputs change just after a rising edge, the timing is as follows:
  - In single mode, `ready_o` asserts at the falling edge of the same cycle.
  - In double mode, `ready_o` asserts one full cycle later.
  - Negation happens at the same-cycle falling edge in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock; both edges used |
| rst_ni | input | 1 | Active-low asynchronous reset |
| done_i | input | NUM_SRC | Per-source transfer-complete indication, active high |
| sel_ni | input | NUM_SRC | Per-source qualifier, active low |
| single_sync_i | input | 1 | 1 = one falling-edge stage, 0 = two stages |
| ready_o | output | 1 | Retimed ready to the processor |

## Verification
Several qualification patterns are applied: each select alone, both selects, and neither select. Together they separate a correct per-source gate and OR from swapped or inverted selects. The same assertion and negation steps are run in both modes, which exposes the one-cycle difference in assertion latency and the equal negation latency. Two narrow pulses complete the set. One is high only across a falling edge: single mode passes it and double mode must reject it. The other is high across a rising edge but low at the next falling edge, which shows that negation bypasses the first stage. An asynchronous reset taken while ready is high checks the immediate clear.

// File: rtl/ready_sync_pkg.sv
`timescale 1ns/100ps
package ready_sync_pkg;
  typedef enum logic {
    SYNC_DOUBLE = 1'b0,
    SYNC_SINGLE = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/ready_qualify.sv
`timescale 1ns/100ps
module ready_qualify #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] done_i,
  input  logic [NUM_SRC-1:0] sel_ni,
  output logic               qual_o
);
  logic [NUM_SRC-1:0] gated;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign gated[g] = done_i[g] & ~sel_ni[g];
  end

  assign qual_o = |gated;
endmodule

// File: rtl/ready_stage_rise.sv
`timescale 1ns/100ps
module ready_stage_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/ready_stage_fall.sv
`timescale 1ns/100ps
module ready_stage_fall
  import ready_sync_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  input  logic stage_i,
  input  logic mode_i,
  output logic ready_o
);
  sync_mode_e mode;
  logic       d;

  assign mode = sync_mode_e'(mode_i);

  // negation bypasses the first stage; assertion needs it in double mode
  always_comb begin
    unique case (mode)
      SYNC_SINGLE: d = qual_i;
      default:     d = qual_i & stage_i;
    endcase
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_o <= 1'b0;
    else         ready_o <= d;
  end
endmodule

// File: rtl/dual_ready_sync.sv
`timescale 1ns/100ps
module dual_ready_sync #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] done_i,
  input  logic [NUM_SRC-1:0] sel_ni,
  input  logic               single_sync_i,
  output logic               ready_o
);
  logic qual;
  logic stage_q;

  ready_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
    .done_i (done_i),
    .sel_ni (sel_ni),
    .qual_o (qual)
  );

  ready_stage_rise u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (qual),
    .q_o    (stage_q)
  );

  ready_stage_fall u_fall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .qual_i  (qual),
    .stage_i (stage_q),
    .mode_i  (single_sync_i),
    .ready_o (ready_o)
  );
endmodule

// File: rtl/dual_ready_sync_chk.sv
`timescale 1ns/100ps
module dual_ready_sync_chk #(
  parameter int NUM_SRC = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] done_i,
  input logic [NUM_SRC-1:0] sel_ni,
  input logic               single_sync_i,
  input logic               stage_q,
  input logic               ready_o
);
  logic qual_c;
  logic pos_seen;
  logic pos_val;

  assign qual_c = |(done_i & ~sel_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_seen <= 1'b0;
      pos_val  <= 1'b0;
    end else begin
      pos_seen <= 1'b1;
      pos_val  <= ready_o;
    end
  end

  // R1 R2
  no_qual_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !qual_c |=> !ready_o);

  // R3
  single_follow_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (single_sync_i && qual_c) |=> ready_o);

  // R4
  double_needs_stage_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!single_sync_i && !stage_q) |=> !ready_o);

  // R4
  double_assert_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!single_sync_i && stage_q && qual_c) |=> ready_o);

  // R6
  fall_only_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    pos_seen |-> (ready_o == pos_val));

  // R7
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!ready_o && !stage_q);
    end
  end
endmodule

bind dual_ready_sync dual_ready_sync_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .done_i        (done_i),
  .sel_ni        (sel_ni),
  .single_sync_i (single_sync_i),
  .stage_q       (stage_q),
  .ready_o       (ready_o)
);

// File: tb/dual_ready_sync_bench.sv
`timescale 1ns/100ps
module dual_ready_sync_bench;
  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [1:0] done_i = 2'b00;
  logic [1:0] sel_ni = 2'b11;
  logic       single_sync_i = 1'b1;
  logic       ready_o;

  int   checks = 0;
  int   failures = 0;
  int   cyc_n = 0;
  bit   finished = 0;
  exp_t exp_q[$];

  dual_ready_sync #(.NUM_SRC(2)) u_dual_ready_sync (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .done_i        (done_i),
    .sel_ni        (sel_ni),
    .single_sync_i (single_sync_i),
    .ready_o       (ready_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: ready_o=%b expected=%b (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  // monitor: sample after the falling edge of each cycle
  initial begin
    forever begin
      @(posedge clk_i);
      cyc_n++;
      #3.5;
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc == cyc_n) begin
          check(ready_o, exp_q[i].val, exp_q[i].tag);
          exp_q.delete(i);
        end
      end
    end
  end

  task automatic drive(input logic [1:0] d, input logic [1:0] s, input logic m);
    @(posedge clk_i);
    #1;
    done_i = d;
    sel_ni = s;
    single_sync_i = m;
  endtask

  task automatic expect_at(input int dlt, input logic v, input string tag);
    exp_q.push_back(exp_t'{cyc_n + dlt, v, tag});
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    @(posedge clk_i);
    #1 check(ready_o, 1'b0, "R7 reset state");
    @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // single mode
    drive(2'b00, 2'b11, 1'b1); expect_at(0, 1'b0, "R7 idle after reset");
    drive(2'b11, 2'b11, 1'b1); expect_at(0, 1'b0, "R1 both deselected");
    drive(2'b01, 2'b10, 1'b1); expect_at(0, 1'b1, "R3 R8 single assert same cycle");
    drive(2'b00, 2'b10, 1'b1); expect_at(0, 1'b0, "R8 single negate same cycle");
    drive(2'b01, 2'b01, 1'b1); expect_at(0, 1'b0, "R1 src0 done but deselected");
    drive(2'b10, 2'b01, 1'b1); expect_at(0, 1'b1, "R2 src1 alone");
    drive(2'b11, 2'b00, 1'b1); expect_at(0, 1'b1, "R2 both done");
    drive(2'b01, 2'b00, 1'b1); expect_at(0, 1'b1, "R2 src0 alone");
    drive(2'b00, 2'b00, 1'b1); expect_at(0, 1'b0, "R3 negate");

    // double mode
    drive(2'b00, 2'b00, 1'b0); expect_at(0, 1'b0, "R4 idle");
    drive(2'b10, 2'b00, 1'b0); expect_at(0, 1'b0, "R4 R8 double not yet");
    expect_at(1, 1'b1, "R8 double assert one cycle later");
    drive(2'b10, 2'b00, 1'b0);
    drive(2'b00, 2'b00, 1'b0); expect_at(0, 1'b0, "R5 R8 double negate same cycle");

    // pulse high only across a falling edge
    drive(2'b01, 2'b00, 1'b1); expect_at(0, 1'b1, "R3 falling-edge pulse seen");
    #1.5 done_i = 2'b00;
    drive(2'b00, 2'b00, 1'b1); expect_at(0, 1'b0, "R3 pulse gone");
    drive(2'b01, 2'b00, 1'b0); expect_at(0, 1'b0, "R4 falling-edge pulse rejected");
    expect_at(1, 1'b0, "R4 falling-edge pulse rejected next");
    #1.5 done_i = 2'b00;
    drive(2'b00, 2'b00, 1'b0);

    // pulse high across a rising edge, low at the falling edge
    drive(2'b00, 2'b00, 1'b0); expect_at(0, 1'b0, "R5 before pulse");
    #1.5 done_i = 2'b01;
    drive(2'b00, 2'b00, 1'b0); expect_at(0, 1'b0, "R5 stage set but level low");
    expect_at(1, 1'b0, "R5 stays low");
    drive(2'b00, 2'b00, 1'b0);

    // asynchronous reset while ready is high
    drive(2'b01, 2'b00, 1'b1); expect_at(0, 1'b1, "R7 ready high before reset");
    @(posedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5 check(ready_o, 1'b0, "R7 asynchronous clear");
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    drive(2'b00, 2'b00, 1'b1); expect_at(0, 1'b0, "R6 R3 after reset release");

    repeat (3) @(posedge clk_i);
    #3.9;
    foreach (exp_q[i]) begin
      failures++;
      $display("FAIL %s: ready_o=never sampled expected=%b", exp_q[i].tag, exp_q[i].val);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule